// File: doc/BRIEF.md
# CSR access legality checker

This block decides, in the same cycle, whether a control/status register access or a wait-for-interrupt instruction must trap as an illegal instruction. It sits beside the register file of a small 32-bit RISC-V core. It sees the current privilege level, the 12-bit register address, the access kind, a flag saying that the set/clear source register is x0, the WFI flag, the counter-enable register contents and the status register contents. It holds no state.

Beside the trap flag it raises a write-ignore flag. That flag tells the register file that a write to a read-only register must be dropped without a trap. Which addresses exist is set at elaboration by parameters: user mode, floating-point registers, the time counter, the number of protection regions, and the width of the cycle and instret counters. A narrow counter turns the writes to its high word, or to both words, into ignored writes.

Top module: `csr_legal_check`

## Requirements
- R1: Access kind encoding is 00 none, 01 write, 10 set, 11 clear. With kind 00 and the WFI flag low, both outputs are low.
- R2: An access to an address the configuration does not implement raises `illegal_o`. The implemented addresses are as follows. 0x001 to 0x003 exist when the floating-point option is set. 0x300, 0x301, 0x304, 0x305, 0x310, 0x340 to 0x344 and 0xF11 to 0xF14 always exist. The protection config registers run from 0x3A0, one per four regions rounded up, and the protection address registers run from 0x3B0, one per region. 0xB00, 0xB02, 0xB80, 0xB82, 0xC00, 0xC02, 0xC80 and 0xC82 always exist. 0xC01 and 0xC81 exist when the time option is set.
- R3: From user mode (`mach_i` = 0), any access to an address whose bits 9:8 are nonzero raises `illegal_o`. Machine mode has no such limit.
- R4: From user mode, an access to a user counter raises `illegal_o` unless the counter-enable bit selected by address bits 1:0 is set. Bit 0 gates cycle (0xC00/0xC80), bit 1 gates time (0xC01/0xC81) and bit 2 gates instret (0xC02/0xC82). Counter-enable bits 31:3 have no effect.
- R5: The WFI flag with `mach_i` low and status bit 21 set raises `illegal_o`. In machine mode, or with bit 21 clear, WFI is legal whatever the other status bits hold.
- R6: 0x306 and 0x30A/0x31A exist only when the user-mode option is set. Otherwise an access to them raises `illegal_o`.
- R7: A write to 0x301, 0x343, 0x344, 0x30A or 0x31A raises `wr_ignore_o` and leaves `illegal_o` low.
- R8: A set or clear access with `src_zero_i` high counts as a read. It raises neither the write-ignore flag nor the read-only-space trap.
- R9: A write to an address whose bits 11:10 are 11 raises `illegal_o`.
- R10: With counter width at most 32, writes to 0xB80/0xB82 are ignored without a trap. With width 0, writes to 0xB00/0xB02 are also ignored that way.
- R11: `wr_ignore_o` is never high together with `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mach_i | input | 1 | 1 = machine mode, 0 = user mode |
| csr_addr_i | input | 12 | Register address of the access |
| acc_op_i | input | 2 | Access kind: 00 none, 01 write, 10 set, 11 clear |
| src_zero_i | input | 1 | Source register of a set/clear is x0 |
| wfi_i | input | 1 | A wait-for-interrupt instruction is executing |
| cnt_en_i | input | 32 | Counter-enable register contents |
| status_i | input | 32 | Status register contents (bit 21 used) |
| illegal_o | output | 1 | Raise an illegal-instruction exception |
| wr_ignore_o | output | 1 | Drop the write silently, no trap |

## Verification
The hardest situation to reach is a user-mode counter read where the correct outcome hinges on one counter-enable bit. This happens while the higher enable bits are all set and the address lies in the read-only space, so three rules meet on one access. The stimulus sweeps every address under every privilege, access kind and x0 flag. The low enable bits rotate with address and combination, and bits 31:3 are held at one. Three differently configured copies are compared at once, so that parameter-dependent existence and the ignored-write variants are each covered.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;

   localparam int ADDR_W     = 12;
   localparam int XLEN       = 32;
   localparam int CTR_GROUPS = 3;
   localparam int TW_BIT     = 21;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_SET   = 2'b10,
      ACC_CLEAR = 2'b11
   } csr_acc_e;

   // floating point
   localparam logic [ADDR_W-1:0] A_FP_FLAGS  = 12'h001;
   localparam logic [ADDR_W-1:0] A_FP_RMODE  = 12'h002;
   localparam logic [ADDR_W-1:0] A_FP_CTRL   = 12'h003;
   // machine setup and handling
   localparam logic [ADDR_W-1:0] A_STAT      = 12'h300;
   localparam logic [ADDR_W-1:0] A_ISA       = 12'h301;
   localparam logic [ADDR_W-1:0] A_IRQ_EN    = 12'h304;
   localparam logic [ADDR_W-1:0] A_VECTOR    = 12'h305;
   localparam logic [ADDR_W-1:0] A_CTR_EN    = 12'h306;
   localparam logic [ADDR_W-1:0] A_ENV_LO    = 12'h30A;
   localparam logic [ADDR_W-1:0] A_STAT_HI   = 12'h310;
   localparam logic [ADDR_W-1:0] A_ENV_HI    = 12'h31A;
   localparam logic [ADDR_W-1:0] A_SCRATCH   = 12'h340;
   localparam logic [ADDR_W-1:0] A_EXC_PC    = 12'h341;
   localparam logic [ADDR_W-1:0] A_CAUSE     = 12'h342;
   localparam logic [ADDR_W-1:0] A_BAD_VAL   = 12'h343;
   localparam logic [ADDR_W-1:0] A_IRQ_PEND  = 12'h344;
   localparam logic [ADDR_W-1:0] A_PROT_CFG  = 12'h3A0;
   localparam logic [ADDR_W-1:0] A_PROT_ADR  = 12'h3B0;
   // machine counters
   localparam logic [ADDR_W-1:0] A_M_CYC_LO  = 12'hB00;
   localparam logic [ADDR_W-1:0] A_M_RET_LO  = 12'hB02;
   localparam logic [ADDR_W-1:0] A_M_CYC_HI  = 12'hB80;
   localparam logic [ADDR_W-1:0] A_M_RET_HI  = 12'hB82;
   // user counters
   localparam logic [ADDR_W-1:0] A_U_CYC_LO  = 12'hC00;
   localparam logic [ADDR_W-1:0] A_U_TIM_LO  = 12'hC01;
   localparam logic [ADDR_W-1:0] A_U_RET_LO  = 12'hC02;
   localparam logic [ADDR_W-1:0] A_U_CYC_HI  = 12'hC80;
   localparam logic [ADDR_W-1:0] A_U_TIM_HI  = 12'hC81;
   localparam logic [ADDR_W-1:0] A_U_RET_HI  = 12'hC82;
   // identification
   localparam logic [ADDR_W-1:0] A_ID_VENDOR = 12'hF11;
   localparam logic [ADDR_W-1:0] A_ID_ARCH   = 12'hF12;
   localparam logic [ADDR_W-1:0] A_ID_IMPL   = 12'hF13;
   localparam logic [ADDR_W-1:0] A_ID_HART   = 12'hF14;

   // a set/clear with x0 as source changes nothing and counts as a read
   function automatic logic acc_modifies(csr_acc_e kind, logic src_zero);
      case (kind)
         ACC_WRITE:           acc_modifies = 1'b1;
         ACC_SET, ACC_CLEAR:  acc_modifies = !src_zero;
         default:             acc_modifies = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
   import csr_legal_pkg::*;
#(
   parameter bit USER_EN     = 1'b1,
   parameter bit FP_EN       = 1'b1,
   parameter bit TIME_EN     = 1'b1,
   parameter int PMP_REGIONS = 8,
   parameter int CNT_WIDTH   = 64
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              impl_o,
   output logic              silent_o,
   output logic              ctr_user_o,
   output logic [1:0]        ctr_sel_o
);

   localparam int PMP_CFG_REGS = (PMP_REGIONS + 3) / 4;
   localparam bit LO_ZERO      = (CNT_WIDTH == 0);
   localparam bit HI_ZERO      = (CNT_WIDTH <= 32);

   logic pmp_hit;
   logic lo_silent;
   logic hi_silent;

   // parameter range checks
   if (PMP_REGIONS < 0 || PMP_REGIONS > 64) begin : g_bad_pmp
      $error("PMP_REGIONS must lie in 0..64");
   end
   if (CNT_WIDTH < 0 || CNT_WIDTH > 64) begin : g_bad_cnt
      $error("CNT_WIDTH must lie in 0..64");
   end

   // protection register window
   if (PMP_REGIONS == 0) begin : g_pmp_none
      assign pmp_hit = 1'b0;
   end else begin : g_pmp
      localparam logic [ADDR_W-1:0] CFG_END = A_PROT_CFG + ADDR_W'(PMP_CFG_REGS);
      localparam logic [ADDR_W-1:0] ADR_END = A_PROT_ADR + ADDR_W'(PMP_REGIONS);
      logic cfg_hit;
      logic adr_hit;
      assign cfg_hit = (addr_i >= A_PROT_CFG) && (addr_i < CFG_END);
      assign adr_hit = (addr_i >= A_PROT_ADR) && (addr_i < ADR_END);
      assign pmp_hit = cfg_hit | adr_hit;
   end

   // counter width variants
   if (LO_ZERO) begin : g_cnt_none
      assign lo_silent = 1'b1;
      assign hi_silent = 1'b1;
   end else if (HI_ZERO) begin : g_cnt_small
      assign lo_silent = 1'b0;
      assign hi_silent = 1'b1;
   end else begin : g_cnt_full
      assign lo_silent = 1'b0;
      assign hi_silent = 1'b0;
   end

   always_comb begin
      impl_o     = 1'b0;
      silent_o   = 1'b0;
      ctr_user_o = 1'b0;
      case (addr_i)
         A_ISA, A_BAD_VAL, A_IRQ_PEND: begin
            impl_o   = 1'b1;
            silent_o = 1'b1;
         end
         A_STAT, A_IRQ_EN, A_VECTOR, A_STAT_HI,
         A_SCRATCH, A_EXC_PC, A_CAUSE,
         A_ID_VENDOR, A_ID_ARCH, A_ID_IMPL, A_ID_HART: begin
            impl_o = 1'b1;
         end
         A_CTR_EN: begin
            impl_o = USER_EN;
         end
         A_ENV_LO, A_ENV_HI: begin
            impl_o   = USER_EN;
            silent_o = USER_EN;
         end
         A_FP_FLAGS, A_FP_RMODE, A_FP_CTRL: begin
            impl_o = FP_EN;
         end
         A_M_CYC_LO, A_M_RET_LO: begin
            impl_o   = 1'b1;
            silent_o = lo_silent;
         end
         A_M_CYC_HI, A_M_RET_HI: begin
            impl_o   = 1'b1;
            silent_o = hi_silent;
         end
         A_U_CYC_LO, A_U_RET_LO, A_U_CYC_HI, A_U_RET_HI: begin
            impl_o     = 1'b1;
            ctr_user_o = 1'b1;
         end
         A_U_TIM_LO, A_U_TIM_HI: begin
            impl_o     = TIME_EN;
            ctr_user_o = TIME_EN;
         end
         default: begin
            impl_o = pmp_hit;
         end
      endcase
   end

   assign ctr_sel_o = addr_i[1:0];

endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
   import csr_legal_pkg::*;
#(
   parameter int GROUPS = CTR_GROUPS
) (
   input  logic              mach_i,
   input  logic [1:0]        priv_field_i,
   input  logic              ctr_user_i,
   input  logic [1:0]        ctr_sel_i,
   input  logic [GROUPS-1:0] ctr_en_i,
   input  logic              wfi_i,
   input  logic              tw_i,
   output logic              deny_o,
   output logic              wfi_trap_o
);

   if (GROUPS < 1 || GROUPS > 4) begin : g_bad_groups
      $error("GROUPS must lie in 1..4");
   end

   logic [GROUPS-1:0] grp_ok;
   logic              ctr_ok;
   logic              field_deny;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_ok[g] = ctr_en_i[g] && (ctr_sel_i == 2'(g));
   end

   assign ctr_ok     = |grp_ok;
   assign field_deny = (priv_field_i != 2'b00);

   always_comb begin
      deny_o = 1'b0;
      if (!mach_i) begin
         if (field_deny)
            deny_o = 1'b1;
         else if (ctr_user_i && !ctr_ok)
            deny_o = 1'b1;
      end
   end

   assign wfi_trap_o = wfi_i && !mach_i && tw_i;

endmodule

// File: rtl/csr_legal_check.sv
module csr_legal_check
   import csr_legal_pkg::*;
#(
   parameter bit USER_EN     = 1'b1,
   parameter bit FP_EN       = 1'b1,
   parameter bit TIME_EN     = 1'b1,
   parameter int PMP_REGIONS = 8,
   parameter int CNT_WIDTH   = 64
) (
   input  logic        mach_i,
   input  logic [11:0] csr_addr_i,
   input  logic [1:0]  acc_op_i,
   input  logic        src_zero_i,
   input  logic        wfi_i,
   input  logic [31:0] cnt_en_i,
   input  logic [31:0] status_i,
   output logic        illegal_o,
   output logic        wr_ignore_o
);

   csr_acc_e   kind;
   logic       active;
   logic       modifies;
   logic       ro_space;
   logic       impl;
   logic       silent;
   logic       ctr_user;
   logic [1:0] ctr_sel;
   logic       deny;
   logic       wfi_trap;
   logic       csr_bad;
   logic       unused_bits;

   assign kind     = csr_acc_e'(acc_op_i);
   assign active   = (kind != ACC_NONE);
   assign modifies = acc_modifies(kind, src_zero_i);
   assign ro_space = (csr_addr_i[11:10] == 2'b11);

   csr_addr_decode #(
      .USER_EN     (USER_EN),
      .FP_EN       (FP_EN),
      .TIME_EN     (TIME_EN),
      .PMP_REGIONS (PMP_REGIONS),
      .CNT_WIDTH   (CNT_WIDTH)
   ) u_decode (
      .addr_i     (csr_addr_i),
      .impl_o     (impl),
      .silent_o   (silent),
      .ctr_user_o (ctr_user),
      .ctr_sel_o  (ctr_sel)
   );

   csr_priv_gate #(
      .GROUPS (CTR_GROUPS)
   ) u_gate (
      .mach_i       (mach_i),
      .priv_field_i (csr_addr_i[9:8]),
      .ctr_user_i   (ctr_user),
      .ctr_sel_i    (ctr_sel),
      .ctr_en_i     (cnt_en_i[CTR_GROUPS-1:0]),
      .wfi_i        (wfi_i),
      .tw_i         (status_i[TW_BIT]),
      .deny_o       (deny),
      .wfi_trap_o   (wfi_trap)
   );

   assign csr_bad     = active && (!impl || deny || (modifies && ro_space));
   assign illegal_o   = csr_bad || wfi_trap;
   assign wr_ignore_o = active && modifies && silent && !illegal_o;

   // counter-enable bits above the groups read as zero; other status bits are not consulted
   assign unused_bits = ^{cnt_en_i[31:CTR_GROUPS], status_i[31:TW_BIT+1], status_i[TW_BIT-1:0]};

endmodule

// File: rtl/csr_legal_sva.sv
module csr_legal_sva (
   input logic        mach_i,
   input logic [11:0] csr_addr_i,
   input logic [1:0]  acc_op_i,
   input logic        src_zero_i,
   input logic        wfi_i,
   input logic        tw_i,
   input logic        illegal_o,
   input logic        wr_ignore_o
);

   logic known;
   logic is_wr;

   assign known = !$isunknown({mach_i, csr_addr_i, acc_op_i, src_zero_i, wfi_i, tw_i,
                               illegal_o, wr_ignore_o});
   assign is_wr = (acc_op_i == 2'b01) || (acc_op_i[1] && !src_zero_i);

   always_comb begin
      if (known) begin
         assert_idle_quiet_R1: assert (!(acc_op_i == 2'b00 && !wfi_i) || (!illegal_o && !wr_ignore_o))
            else $error("idle cycle raised a flag");
         assert_user_field_R3: assert (!(!mach_i && acc_op_i != 2'b00 && csr_addr_i[9:8] != 2'b00) || illegal_o)
            else $error("user access to privileged field not trapped");
         assert_wfi_timeout_R5: assert (!(wfi_i && !mach_i && tw_i) || illegal_o)
            else $error("user WFI with timeout bit not trapped");
         assert_silent_write_R7: assert (!(mach_i && !wfi_i && acc_op_i == 2'b01 &&
                                          (csr_addr_i == 12'h301 || csr_addr_i == 12'h343 ||
                                           csr_addr_i == 12'h344)) || (wr_ignore_o && !illegal_o))
            else $error("read-only write not silently ignored");
         assert_x0_read_R8: assert (!(acc_op_i[1] && src_zero_i) || !wr_ignore_o)
            else $error("x0 set/clear marked as ignored write");
         assert_ro_space_R9: assert (!(acc_op_i != 2'b00 && is_wr && csr_addr_i[11:10] == 2'b11) ||
                                    (illegal_o && !wr_ignore_o))
            else $error("write to read-only space not trapped");
         assert_exclusive_R11: assert (!(illegal_o && wr_ignore_o))
            else $error("both flags high");
      end
   end

endmodule

bind csr_legal_check csr_legal_sva u_sva (
   .mach_i      (mach_i),
   .csr_addr_i  (csr_addr_i),
   .acc_op_i    (acc_op_i),
   .src_zero_i  (src_zero_i),
   .wfi_i       (wfi_i),
   .tw_i        (status_i[21]),
   .illegal_o   (illegal_o),
   .wr_ignore_o (wr_ignore_o)
);

// File: tb/sim_csr_legal_check.sv
module sim_csr_legal_check;

   logic        clk = 1'b0;
   logic        mach = 1'b1;
   logic [11:0] addr = '0;
   logic [1:0]  op = '0;
   logic        sz = 1'b0;
   logic        wfi = 1'b0;
   logic [31:0] ce = '0;
   logic [31:0] st = '0;
   logic        ill0, ign0, ill1, ign1, ill2, ign2;
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   csr_legal_check u0 (
      .mach_i(mach), .csr_addr_i(addr), .acc_op_i(op), .src_zero_i(sz), .wfi_i(wfi),
      .cnt_en_i(ce), .status_i(st), .illegal_o(ill0), .wr_ignore_o(ign0));

   csr_legal_check #(.USER_EN(1'b0), .FP_EN(1'b0), .TIME_EN(1'b0), .PMP_REGIONS(0), .CNT_WIDTH(0)) u1 (
      .mach_i(mach), .csr_addr_i(addr), .acc_op_i(op), .src_zero_i(sz), .wfi_i(wfi),
      .cnt_en_i(ce), .status_i(st), .illegal_o(ill1), .wr_ignore_o(ign1));

   csr_legal_check #(.PMP_REGIONS(13), .CNT_WIDTH(32)) u2 (
      .mach_i(mach), .csr_addr_i(addr), .acc_op_i(op), .src_zero_i(sz), .wfi_i(wfi),
      .cnt_en_i(ce), .status_i(st), .illegal_o(ill2), .wr_ignore_o(ign2));

   // behavioural reference written from the requirements
   function automatic void model(input int cfg, output bit ill, output bit ign, output string tag);
      bit user_en = 1, fp_en = 1, time_en = 1;
      int pmp = 8, cw = 64;
      int ai = int'(addr);
      bit impl = 0, silent = 0, ctr = 0, access, wr, user;
      if (cfg == 1) begin user_en = 0; fp_en = 0; time_en = 0; pmp = 0; cw = 0; end
      if (cfg == 2) begin pmp = 13; cw = 32; end
      if (ai >= 1 && ai <= 3) impl = fp_en;
      else if (ai == 'h300 || ai == 'h304 || ai == 'h305 || ai == 'h310 ||
               (ai >= 'h340 && ai <= 'h342) || (ai >= 'hF11 && ai <= 'hF14)) impl = 1;
      else if (ai == 'h301 || ai == 'h343 || ai == 'h344) begin impl = 1; silent = 1; end
      else if (ai == 'h306) impl = user_en;
      else if (ai == 'h30A || ai == 'h31A) begin impl = user_en; silent = 1; end
      else if (ai >= 'h3A0 && ai < 'h3A0 + (pmp + 3) / 4) impl = 1;
      else if (ai >= 'h3B0 && ai < 'h3B0 + pmp) impl = 1;
      else if (ai == 'hB00 || ai == 'hB02) begin impl = 1; silent = (cw == 0); end
      else if (ai == 'hB80 || ai == 'hB82) begin impl = 1; silent = (cw <= 32); end
      else if (ai == 'hC00 || ai == 'hC02 || ai == 'hC80 || ai == 'hC82) begin impl = 1; ctr = 1; end
      else if (ai == 'hC01 || ai == 'hC81) begin impl = time_en; ctr = time_en; end
      access = (op != 2'b00);
      wr     = (op == 2'b01) || (op[1] && !sz);
      user   = !mach;
      ill = 0; ign = 0; tag = "R1";
      if (access) begin
         if (!impl) begin
            ill = 1;
            tag = (ai == 'h306 || ai == 'h30A || ai == 'h31A) ? "R6" : "R2";
         end else if (user && addr[9:8] != 2'b00) begin ill = 1; tag = "R3"; end
         else if (user && ctr && !ce[addr[1:0]]) begin ill = 1; tag = "R4"; end
         else if (wr && addr[11:10] == 2'b11) begin ill = 1; tag = "R9"; end
         else if (wr && silent) begin
            ign = 1;
            tag = (ai >= 'hB00 && ai < 'hC00) ? "R10" : "R7";
         end else tag = (op[1] && sz) ? "R8" : "R2";
      end
      if (wfi && user && st[21]) begin ill = 1; ign = 0; tag = "R5"; end
      if (ill) ign = 0;   // R11
   endfunction

   task automatic check(input string tag, input string what, input logic got, input bit exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h op=%b mach=%b: got %b expected %b", tag, what, addr, op, mach, got, exp);
      end
   endtask

   task automatic cmp_all();
      bit e_ill, e_ign;
      string t;
      model(0, e_ill, e_ign, t); check(t, "u0 illegal", ill0, e_ill); check(t, "u0 ignore", ign0, e_ign);
      model(1, e_ill, e_ign, t); check(t, "u1 illegal", ill1, e_ill); check(t, "u1 ignore", ign1, e_ign);
      model(2, e_ill, e_ign, t); check(t, "u2 illegal", ill2, e_ill); check(t, "u2 ignore", ign2, e_ign);
   endtask

   task automatic step(input logic m, input logic [11:0] a, input logic [1:0] o, input logic z,
                       input logic w, input logic [31:0] c, input logic [31:0] s);
      @(posedge clk);
      mach = m; addr = a; op = o; sz = z; wfi = w; ce = c; st = s;
      @(negedge clk);
      cmp_all();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: idle state
      step(1, 12'h300, 2'b00, 0, 0, 32'h0, 32'hFFFF_FFFF);
      check("R1", "idle illegal", ill0, 0);
      check("R1", "idle ignore", ign0, 0);
      // R5: WFI combinations
      step(0, 12'h000, 2'b00, 0, 1, 32'h0, 32'h0020_0000);
      check("R5", "user wfi tw", ill0, 1);
      step(0, 12'h000, 2'b00, 0, 1, 32'h0, 32'hFFDF_FFFF);
      check("R5", "user wfi no tw", ill0, 0);
      step(1, 12'h000, 2'b00, 0, 1, 32'h0, 32'h0020_0000);
      check("R5", "machine wfi tw", ill0, 0);
      // R7: silent writes
      step(1, 12'h301, 2'b01, 0, 0, 32'h0, 32'h0);
      check("R7", "isa write ignore", ign0, 1);
      check("R7", "isa write illegal", ill0, 0);
      step(1, 12'h30A, 2'b10, 0, 0, 32'h0, 32'h0);
      check("R7", "env set ignore", ign0, 1);
      // R8: x0 set/clear is a read
      step(1, 12'h343, 2'b11, 1, 0, 32'h0, 32'h0);
      check("R8", "x0 clear ignore", ign0, 0);
      step(1, 12'hC00, 2'b10, 1, 0, 32'h0, 32'h0);
      check("R8", "x0 set counter illegal", ill0, 0);
      // R9: write into read-only space
      step(1, 12'hC00, 2'b01, 0, 0, 32'h0, 32'h0);
      check("R9", "counter write illegal", ill0, 1);
      // R4: user counter gating, upper enable bits without effect
      step(0, 12'hC02, 2'b10, 1, 0, 32'hFFFF_FFF8, 32'h0);
      check("R4", "instret disabled", ill0, 1);
      step(0, 12'hC02, 2'b10, 1, 0, 32'h0000_0004, 32'h0);
      check("R4", "instret enabled", ill0, 0);
      // R3: user access to machine field
      step(0, 12'h340, 2'b10, 1, 0, 32'hFFFF_FFFF, 32'h0);
      check("R3", "user scratch", ill0, 1);
      // R6: existence depends on user option
      step(1, 12'h306, 2'b01, 0, 0, 32'h0, 32'h0);
      check("R6", "u0 cnt-enable", ill0, 0);
      check("R6", "u1 cnt-enable", ill1, 1);
      // R10: narrow counters
      step(1, 12'hB80, 2'b01, 0, 0, 32'h0, 32'h0);
      check("R10", "u0 high write", ign0, 0);
      check("R10", "u2 high write", ign2, 1);
      step(1, 12'hB00, 2'b01, 0, 0, 32'h0, 32'h0);
      check("R10", "u2 low write", ign2, 0);
      check("R10", "u1 low write", ign1, 1);
      // R2: unimplemented
      step(1, 12'h7C0, 2'b10, 1, 0, 32'h0, 32'h0);
      check("R2", "unimplemented", ill0, 1);

      // full sweep against the reference model
      for (int a = 0; a < 4096; a++) begin
         for (int k = 0; k < 16; k++) begin
            logic [31:0] c;
            c = {29'h1FFF_FFFF, 3'((a * 7 + k * 3) % 8)};
            step(k[0], 12'(a), k[2:1], k[3], 0, c, 32'h0);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule